// File: doc/BRIEF.md
# Control Endpoint Packet Buffer Controller

This block sits between a serial bus engine and software for the bidirectional control endpoint of a USB-style device. One byte array of `DEPTH` entries (eight by default) is shared by both directions and holds a single packet at a time. Received packets can be read by software, and packets written by software are sent to the host. A six-state sequencer decides which side owns the storage. Its states are idle, armed for receive, receiving, filling for transmit, armed for transmit and transmitting. The state is never exposed as a value.

Software arms reception with a receive-enable pulse. The next accepted OUT or SETUP token opens the storage to the engine's data bytes. A packet that ends with a CRC or bit-stuff error is dropped without any report, and the block goes back to waiting for the next packet. Software fills a transmit packet by writing bytes and arms it with a transmit-enable pulse. If transmit-enable is given with no bytes written, the armed packet has zero length. The packet is kept in the array until the engine reports that it was delivered, so a failed attempt is repeated from its first byte on the next IN token. A SETUP token takes the storage back from a pending transmit packet. Flush empties the storage from any state.

Two readiness outputs tell the engine whether an OUT packet or an IN request can be served. A default-address enable lets tokens sent to device address 0 be accepted.

Top module: `ctl_ep_buf`

## Requirements
- R1: After a synchronous active-low reset, `out_rdy`, `in_rdy`, `tx_busy`, `rx_ready`, `tx_done` and `ovf_flag` are 0 and `rx_count` is 0.
- R2: After a `sw_rx_en` pulse in idle, `out_rdy` is 1. An accepted OUT (`tok_kind`=01) or SETUP (`tok_kind`=11) token drops `out_rdy` and collects `rx_byte` values on `rx_byte_vld` cycles. An error-free `rx_eop` raises `rx_ready` for exactly one cycle, and in that cycle `rx_count` holds the byte count. `sw_rd_data` then shows the bytes in arrival order, advancing one byte on each `sw_rd_req`.
- R3: A packet whose `rx_eop` comes with `rx_crc_err` or `rx_stuff_err` gives no `rx_ready`. After it, `rx_count` is 0 and `out_rdy` is 1 again, so the next packet is accepted without a new `sw_rx_en`.
- R4: While unread received bytes remain, `sw_rx_en` has no effect. Once the last byte has been read, or at once for a zero-length packet, the block is idle and a `sw_rx_en` pulse raises `out_rdy`.
- R5: A token is accepted when `tok_own_addr` is 1, or when `tok_zero_addr` is 1 and `cfg_dflt_en` is 1. Any other token has no effect.
- R6: Bytes written with `sw_wr_vld` followed by a `sw_tx_en` pulse raise `in_rdy`. An accepted IN token (`tok_kind`=10) sets `tx_busy` and clears `in_rdy`. `tx_byte` shows the written bytes in order, advancing on each `tx_pull`, and `tx_empty` becomes 1 after the last byte.
- R7: A `sw_tx_en` pulse in idle with no bytes written arms a zero-length packet: `in_rdy` rises, and after the IN token `tx_empty` is 1 at once.
- R8: A `tx_end_err` pulse while transmitting clears `tx_busy` and sets `in_rdy` again. The next IN token resends the same bytes from the first one.
- R9: A `tx_end_ok` pulse while transmitting gives a one-cycle `tx_done`, clears `tx_busy` and `in_rdy`, and empties the storage.
- R10: A SETUP token accepted while a transmit packet is being filled or is armed discards that packet, drops `in_rdy`, and receives the SETUP data as in R2.
- R11: A `sw_flush` pulse from any state empties the storage, clears `rx_count` and `ovf_flag`, and returns to idle.
- R12: At most `DEPTH` bytes are stored. Further software writes or received bytes are dropped and set the sticky `ovf_flag`, which only flush or reset clears.
- R13: A token that the current state does not expect has no effect: an IN token outside the armed-transmit state, and an OUT token outside the armed-receive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dflt_en | input | 1 | Accept tokens sent to address 0 |
| tok_kind | input | 2 | Decoded token: 00 none, 01 OUT, 10 IN, 11 SETUP |
| tok_own_addr | input | 1 | Token addressed to the device's assigned address |
| tok_zero_addr | input | 1 | Token addressed to address 0 |
| rx_byte_vld | input | 1 | Received data byte valid |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End of received packet |
| rx_crc_err | input | 1 | CRC error, sampled with `rx_eop` |
| rx_stuff_err | input | 1 | Bit-stuff error, sampled with `rx_eop` |
| tx_pull | input | 1 | Engine consumed `tx_byte` |
| tx_end_ok | input | 1 | Transmission acknowledged by host |
| tx_end_err | input | 1 | Transmission failed |
| sw_rx_en | input | 1 | Software arms reception |
| sw_tx_en | input | 1 | Software arms transmission |
| sw_flush | input | 1 | Software empties the storage |
| sw_wr_vld | input | 1 | Software transmit byte write |
| sw_wr_data | input | 8 | Software transmit byte |
| sw_rd_req | input | 1 | Software consumes `sw_rd_data` |
| out_rdy | output | 1 | Armed for an OUT/SETUP packet |
| in_rdy | output | 1 | Armed to answer an IN token |
| tx_busy | output | 1 | Transmission in progress |
| tx_byte | output | 8 | Next byte to transmit |
| tx_empty | output | 1 | No byte left to transmit |
| tx_done | output | 1 | One-cycle pulse on successful transmission |
| rx_ready | output | 1 | One-cycle pulse on error-free reception |
| rx_count | output | $clog2(DEPTH+1) (4) | Byte count of the last good packet |
| sw_rd_data | output | 8 | Next received byte for software |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The embedded properties take the bus engine to be well behaved. It raises `rx_eop` only while a packet is open and never in the same cycle as a data byte. It pulls transmit bytes only while `tx_empty` is low. It reports at most one of `tx_end_ok` and `tx_end_err`, and only while `tx_busy` is set. The bench drives each of these from small tasks that follow that protocol, one event per cycle. It then sweeps every packet length from 0 to `DEPTH`, both error kinds, both receive token kinds and every token-address combination, and computes each expected byte from a formula of seed and position.

// File: rtl/ctl_ep_pkg.sv
// Shared types for the control endpoint packet buffer.
// Assumes: token codes are produced by an upstream decoder.
package ctl_ep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RXWAIT,
        ST_RX,
        ST_TX,
        ST_TXWAIT,
        ST_TXFILL
    } ep_state_t;

    typedef enum logic [1:0] {
        TK_NONE  = 2'b00,
        TK_OUT   = 2'b01,
        TK_IN    = 2'b10,
        TK_SETUP = 2'b11
    } tok_kind_t;

endpackage

// File: rtl/ctl_ep_tokfilt.sv
// Token filter: turns a decoded token plus address-match flags into one
// accepted-event strobe per token kind.
// Assumes: tok_kind is valid for one cycle per token; no token is 2'b00.
module ctl_ep_tokfilt
    import ctl_ep_pkg::*;
(
    input  logic [1:0] tok_kind,
    input  logic       tok_own_addr,
    input  logic       tok_zero_addr,
    input  logic       dflt_en,
    output logic       acc_out,
    output logic       acc_in,
    output logic       acc_setup
);

    logic addr_ok;

    // Decide whether the token targets this endpoint, then split by kind.
    always_comb begin
        addr_ok   = tok_own_addr | (tok_zero_addr & dflt_en);
        acc_out   = addr_ok && (tok_kind == TK_OUT);
        acc_in    = addr_ok && (tok_kind == TK_IN);
        acc_setup = addr_ok && (tok_kind == TK_SETUP);
    end

endmodule

// File: rtl/ctl_ep_store.sv
// Single-packet byte storage with a fill count and a read pointer.
// Writes append at the fill count; reads advance the read pointer, which
// never passes the fill count. clr empties it and wins over everything.
// Assumes: the controller drives at most one of rd_adv / rd_rewind usefully.
module ctl_ep_store #(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_adv,
    input  logic          rd_rewind,
    output logic [CW-1:0] cnt,
    output logic [7:0]    rd_data,
    output logic          full,
    output logic          drained,
    output logic          rd_last
);

    logic [7:0]    mem_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rptr_q;
    logic          wr_ok;

    // Status decode from the two pointers.
    always_comb begin
        full    = (cnt_q == CW'(DEPTH));
        drained = (rptr_q == cnt_q);
        rd_last = (CW'(rptr_q + 1'b1) == cnt_q);
        wr_ok   = wr_en && !full && !clr;
        cnt     = cnt_q;
        rd_data = mem_q[rptr_q[AW-1:0]];
    end

    // Fill count and read pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rptr_q <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_ok) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (rd_rewind) begin
                rptr_q <= '0;
            end else if (rd_adv && !drained) begin
                rptr_q <= rptr_q + 1'b1;
            end
        end
    end

    // Byte array write at the current fill position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_ok) begin
            mem_q[cnt_q[AW-1:0]] <= wr_data;
        end
    end

    p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    p_full_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !clr) |=> (cnt_q == $past(cnt_q)));

    p_rptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rptr_q <= cnt_q);

    p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rewind && !clr) |=> (rptr_q == '0));

endmodule

// File: rtl/ctl_ep_fsm.sv
// Six-state sequencer deciding which side owns the shared storage, plus
// the receive-ready / transmit-done pulses, byte count and overflow flag.
// Priority: flush, then SETUP (when allowed), then per-state events.
// Assumes: rx_eop never coincides with rx_byte_vld; the engine reports at
// most one of tx_end_ok / tx_end_err, and only while transmitting.
module ctl_ep_fsm
    import ctl_ep_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_out,
    input  logic          acc_in,
    input  logic          acc_setup,
    input  logic          rx_byte_vld,
    input  logic [7:0]    rx_byte,
    input  logic          rx_eop,
    input  logic          rx_crc_err,
    input  logic          rx_stuff_err,
    input  logic          sw_rx_en,
    input  logic          sw_tx_en,
    input  logic          sw_flush,
    input  logic          sw_wr_vld,
    input  logic [7:0]    sw_wr_data,
    input  logic          sw_rd_req,
    input  logic          tx_pull,
    input  logic          tx_end_ok,
    input  logic          tx_end_err,
    input  logic [CW-1:0] st_cnt,
    input  logic          st_full,
    input  logic          st_drained,
    input  logic          st_rd_last,
    output logic          st_clr,
    output logic          st_wr_en,
    output logic [7:0]    st_wr_data,
    output logic          st_rd_adv,
    output logic          st_rd_rewind,
    output logic          out_rdy,
    output logic          in_rdy,
    output logic          tx_busy,
    output logic          rx_ready,
    output logic          tx_done,
    output logic [CW-1:0] rx_count,
    output logic          ovf_flag
);

    ep_state_t     state_q, state_n;
    logic          got_q, got_n;
    logic          rdy_q, rdy_n;
    logic          done_q, done_n;
    logic          ovf_q, ovf_n;
    logic [CW-1:0] rcnt_q, rcnt_n;
    logic          setup_ok;

    // Next-state and storage-control decode.
    always_comb begin
        state_n      = state_q;
        got_n        = got_q;
        rdy_n        = 1'b0;
        done_n       = 1'b0;
        ovf_n        = ovf_q;
        rcnt_n       = rcnt_q;
        st_clr       = 1'b0;
        st_wr_en     = 1'b0;
        st_wr_data   = sw_wr_data;
        st_rd_adv    = 1'b0;
        st_rd_rewind = 1'b0;
        setup_ok     = acc_setup && (state_q inside {ST_IDLE, ST_RXWAIT,
                                                      ST_TXFILL, ST_TXWAIT});
        if (sw_flush) begin
            state_n = ST_IDLE;
            st_clr  = 1'b1;
            got_n   = 1'b0;
            ovf_n   = 1'b0;
            rcnt_n  = '0;
        end else if (setup_ok) begin
            state_n = ST_RX;
            st_clr  = 1'b1;
            got_n   = 1'b0;
            rcnt_n  = '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (sw_wr_vld) begin
                        state_n  = ST_TXFILL;
                        st_wr_en = 1'b1;
                    end else if (sw_tx_en) begin
                        state_n = ST_TXWAIT;
                    end else if (sw_rx_en) begin
                        state_n = ST_RXWAIT;
                    end
                end
                ST_TXFILL: begin
                    if (sw_wr_vld) begin
                        if (st_full) begin
                            ovf_n = 1'b1;
                        end else begin
                            st_wr_en = 1'b1;
                        end
                    end
                    if (sw_tx_en) begin
                        state_n = ST_TXWAIT;
                    end
                end
                ST_TXWAIT: begin
                    if (acc_in) begin
                        state_n      = ST_TX;
                        st_rd_rewind = 1'b1;
                    end
                end
                ST_TX: begin
                    if (tx_end_ok) begin
                        state_n = ST_IDLE;
                        st_clr  = 1'b1;
                        done_n  = 1'b1;
                    end else if (tx_end_err) begin
                        state_n      = ST_TXWAIT;
                        st_rd_rewind = 1'b1;
                    end else if (tx_pull && !st_drained) begin
                        st_rd_adv = 1'b1;
                    end
                end
                ST_RXWAIT: begin
                    if (acc_out) begin
                        state_n = ST_RX;
                        st_clr  = 1'b1;
                        got_n   = 1'b0;
                        rcnt_n  = '0;
                    end
                end
                ST_RX: begin
                    if (!got_q) begin
                        if (rx_eop) begin
                            if (rx_crc_err || rx_stuff_err) begin
                                state_n = ST_RXWAIT;
                                st_clr  = 1'b1;
                            end else begin
                                rdy_n  = 1'b1;
                                rcnt_n = st_cnt;
                                if (st_cnt == '0) begin
                                    state_n = ST_IDLE;
                                end else begin
                                    got_n = 1'b1;
                                end
                            end
                        end else if (rx_byte_vld) begin
                            if (st_full) begin
                                ovf_n = 1'b1;
                            end else begin
                                st_wr_en   = 1'b1;
                                st_wr_data = rx_byte;
                            end
                        end
                    end else if (sw_rd_req && !st_drained) begin
                        st_rd_adv = 1'b1;
                        if (st_rd_last) begin
                            state_n = ST_IDLE;
                            st_clr  = 1'b1;
                            got_n   = 1'b0;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Register the sequencer state and the reported status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            got_q   <= 1'b0;
            rdy_q   <= 1'b0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            got_q   <= got_n;
            rdy_q   <= rdy_n;
            done_q  <= done_n;
            ovf_q   <= ovf_n;
            rcnt_q  <= rcnt_n;
        end
    end

    // Output decode toward the engine and software.
    always_comb begin
        out_rdy  = (state_q == ST_RXWAIT);
        in_rdy   = (state_q == ST_TXWAIT);
        tx_busy  = (state_q == ST_TX);
        rx_ready = rdy_q;
        tx_done  = done_q;
        rx_count = rcnt_q;
        ovf_flag = ovf_q;
    end

    p_rdy_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> !rdy_q);

    p_bad_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX && !got_q && rx_eop && (rx_crc_err || rx_stuff_err)
         && !sw_flush) |=> (state_q == ST_RXWAIT && !rdy_q));

    p_txerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX && tx_end_err && !tx_end_ok && !sw_flush)
        |=> (state_q == ST_TXWAIT));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !sw_flush) |=> ovf_q);

    p_tx_entry_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_TXWAIT && state_q != ST_TX) |=> (state_q != ST_TX));

endmodule

// File: rtl/ctl_ep_buf.sv
// Control endpoint packet buffer: token filter, sequencer and one shared
// DEPTH-byte packet store. Transmit and software read data are taken
// straight from the store at the read pointer.
// Assumes: one engine event per cycle as listed in ctl_ep_fsm.
module ctl_ep_buf #(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dflt_en,
    input  logic [1:0]    tok_kind,
    input  logic          tok_own_addr,
    input  logic          tok_zero_addr,
    input  logic          rx_byte_vld,
    input  logic [7:0]    rx_byte,
    input  logic          rx_eop,
    input  logic          rx_crc_err,
    input  logic          rx_stuff_err,
    input  logic          tx_pull,
    input  logic          tx_end_ok,
    input  logic          tx_end_err,
    input  logic          sw_rx_en,
    input  logic          sw_tx_en,
    input  logic          sw_flush,
    input  logic          sw_wr_vld,
    input  logic [7:0]    sw_wr_data,
    input  logic          sw_rd_req,
    output logic          out_rdy,
    output logic          in_rdy,
    output logic          tx_busy,
    output logic [7:0]    tx_byte,
    output logic          tx_empty,
    output logic          tx_done,
    output logic          rx_ready,
    output logic [CW-1:0] rx_count,
    output logic [7:0]    sw_rd_data,
    output logic          ovf_flag
);

    logic          acc_out, acc_in, acc_setup;
    logic          st_clr, st_wr_en, st_rd_adv, st_rd_rewind;
    logic [7:0]    st_wr_data, st_rd_data;
    logic [CW-1:0] st_cnt;
    logic          st_full, st_drained, st_rd_last;

    ctl_ep_tokfilt u_tokfilt (
        .tok_kind      (tok_kind),
        .tok_own_addr  (tok_own_addr),
        .tok_zero_addr (tok_zero_addr),
        .dflt_en       (cfg_dflt_en),
        .acc_out       (acc_out),
        .acc_in        (acc_in),
        .acc_setup     (acc_setup)
    );

    ctl_ep_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_out      (acc_out),
        .acc_in       (acc_in),
        .acc_setup    (acc_setup),
        .rx_byte_vld  (rx_byte_vld),
        .rx_byte      (rx_byte),
        .rx_eop       (rx_eop),
        .rx_crc_err   (rx_crc_err),
        .rx_stuff_err (rx_stuff_err),
        .sw_rx_en     (sw_rx_en),
        .sw_tx_en     (sw_tx_en),
        .sw_flush     (sw_flush),
        .sw_wr_vld    (sw_wr_vld),
        .sw_wr_data   (sw_wr_data),
        .sw_rd_req    (sw_rd_req),
        .tx_pull      (tx_pull),
        .tx_end_ok    (tx_end_ok),
        .tx_end_err   (tx_end_err),
        .st_cnt       (st_cnt),
        .st_full      (st_full),
        .st_drained   (st_drained),
        .st_rd_last   (st_rd_last),
        .st_clr       (st_clr),
        .st_wr_en     (st_wr_en),
        .st_wr_data   (st_wr_data),
        .st_rd_adv    (st_rd_adv),
        .st_rd_rewind (st_rd_rewind),
        .out_rdy      (out_rdy),
        .in_rdy       (in_rdy),
        .tx_busy      (tx_busy),
        .rx_ready     (rx_ready),
        .tx_done      (tx_done),
        .rx_count     (rx_count),
        .ovf_flag     (ovf_flag)
    );

    ctl_ep_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (st_clr),
        .wr_en     (st_wr_en),
        .wr_data   (st_wr_data),
        .rd_adv    (st_rd_adv),
        .rd_rewind (st_rd_rewind),
        .cnt       (st_cnt),
        .rd_data   (st_rd_data),
        .full      (st_full),
        .drained   (st_drained),
        .rd_last   (st_rd_last)
    );

    // Both consumers see the byte at the read pointer.
    always_comb begin
        tx_byte    = st_rd_data;
        sw_rd_data = st_rd_data;
        tx_empty   = st_drained;
    end

endmodule

// File: tb/ctl_ep_buf_tb_top.sv
// Self-checking bench: sweeps packet lengths 0..DEPTH in both directions,
// error kinds, token addressing, retry, SETUP takeover, flush, overflow.
module ctl_ep_buf_tb_top;

    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [1:0] K_OUT = 2'b01, K_IN = 2'b10, K_SETUP = 2'b11;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_dflt_en = 1'b0;
    logic [1:0]    tok_kind = 2'b00;
    logic          tok_own_addr = 1'b0, tok_zero_addr = 1'b0;
    logic          rx_byte_vld = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          rx_eop = 1'b0, rx_crc_err = 1'b0, rx_stuff_err = 1'b0;
    logic          tx_pull = 1'b0, tx_end_ok = 1'b0, tx_end_err = 1'b0;
    logic          sw_rx_en = 1'b0, sw_tx_en = 1'b0, sw_flush = 1'b0;
    logic          sw_wr_vld = 1'b0;
    logic [7:0]    sw_wr_data = '0;
    logic          sw_rd_req = 1'b0;
    logic          out_rdy, in_rdy, tx_busy, tx_empty, tx_done, rx_ready;
    logic          ovf_flag;
    logic [7:0]    tx_byte, sw_rd_data;
    logic [CW-1:0] rx_count;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    ctl_ep_buf #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dflt_en(cfg_dflt_en),
        .tok_kind(tok_kind), .tok_own_addr(tok_own_addr),
        .tok_zero_addr(tok_zero_addr), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_crc_err(rx_crc_err),
        .rx_stuff_err(rx_stuff_err), .tx_pull(tx_pull),
        .tx_end_ok(tx_end_ok), .tx_end_err(tx_end_err),
        .sw_rx_en(sw_rx_en), .sw_tx_en(sw_tx_en), .sw_flush(sw_flush),
        .sw_wr_vld(sw_wr_vld), .sw_wr_data(sw_wr_data),
        .sw_rd_req(sw_rd_req), .out_rdy(out_rdy), .in_rdy(in_rdy),
        .tx_busy(tx_busy), .tx_byte(tx_byte), .tx_empty(tx_empty),
        .tx_done(tx_done), .rx_ready(rx_ready), .rx_count(rx_count),
        .sw_rd_data(sw_rd_data), .ovf_flag(ovf_flag)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) % 256);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_rx_en();   sw_rx_en = 1;   step(); sw_rx_en = 0;   endtask
    task automatic do_tx_en();   sw_tx_en = 1;   step(); sw_tx_en = 0;   endtask
    task automatic do_flush();   sw_flush = 1;   step(); sw_flush = 0;   endtask
    task automatic do_end_ok();  tx_end_ok = 1;  step(); tx_end_ok = 0;  endtask
    task automatic do_end_err(); tx_end_err = 1; step(); tx_end_err = 0; endtask

    task automatic tok(input logic [1:0] k, input logic own, input logic zero);
        tok_kind = k; tok_own_addr = own; tok_zero_addr = zero;
        step();
        tok_kind = 2'b00; tok_own_addr = 0; tok_zero_addr = 0;
    endtask

    task automatic rx_body(input int n, input int seed, input int err);
        for (int i = 0; i < n; i++) begin
            rx_byte_vld = 1; rx_byte = pat(seed, i);
            step();
        end
        rx_byte_vld = 0;
        rx_eop = 1; rx_crc_err = (err == 1); rx_stuff_err = (err == 2);
        step();
        rx_eop = 0; rx_crc_err = 0; rx_stuff_err = 0;
    endtask

    task automatic sw_write(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            sw_wr_vld = 1; sw_wr_data = pat(seed, i);
            step();
        end
        sw_wr_vld = 0;
    endtask

    task automatic sw_read_chk(input int n, input int seed, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, sw_rd_data, pat(seed, i));
            sw_rd_req = 1;
            step();
            sw_rd_req = 0;
        end
    endtask

    task automatic tx_pull_chk(input int n, input int seed, input string req);
        for (int i = 0; i < n; i++) begin
            chk({req, " not empty"}, tx_empty, 0);
            chk({req, " byte"}, tx_byte, pat(seed, i));
            tx_pull = 1;
            step();
            tx_pull = 0;
        end
        chk({req, " empty at end"}, tx_empty, 1);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state
        chk("R1 out_rdy", out_rdy, 0);   chk("R1 in_rdy", in_rdy, 0);
        chk("R1 tx_busy", tx_busy, 0);   chk("R1 rx_ready", rx_ready, 0);
        chk("R1 tx_done", tx_done, 0);   chk("R1 rx_count", rx_count, 0);
        chk("R1 ovf", ovf_flag, 0);

        // R2 / R3 / R4: receive sweep over every length and error kind
        for (int n = 0; n <= DEPTH; n++) begin
            do_flush();
            do_rx_en();
            chk("R2 armed", out_rdy, 1);
            for (int e = 1; e <= 2; e++) begin
                tok(K_OUT, 1, 0);
                chk("R2 token taken", out_rdy, 0);
                rx_body(n, n + e, e);
                chk("R3 no ready", rx_ready, 0);
                chk("R3 waiting again", out_rdy, 1);
                chk("R3 count", rx_count, 0);
            end
            tok((n % 2 == 1) ? K_SETUP : K_OUT, 1, 0);
            rx_body(n, n + 50, 0);
            chk("R2 ready pulse", rx_ready, 1);
            chk("R2 count", rx_count, n);
            if (n > 0) begin
                do_rx_en();
                chk("R4 held while unread", out_rdy, 0);
            end else begin
                step();
            end
            chk("R2 ready one cycle", rx_ready, 0);
            sw_read_chk(n, n + 50, "R2 data");
            do_rx_en();
            chk("R4 idle after drain", out_rdy, 1);
        end

        // R5: token address filtering
        do_flush();
        do_rx_en();
        cfg_dflt_en = 0;
        tok(K_OUT, 0, 1); chk("R5 zero addr off", out_rdy, 1);
        tok(K_OUT, 0, 0); chk("R5 no addr", out_rdy, 1);
        cfg_dflt_en = 1;
        tok(K_OUT, 0, 0); chk("R5 no addr dflt", out_rdy, 1);
        tok(K_OUT, 0, 1); chk("R5 zero addr on", out_rdy, 0);
        rx_body(1, 77, 0);
        chk("R5 ready", rx_ready, 1);
        sw_read_chk(1, 77, "R5 data");
        cfg_dflt_en = 0;

        // R6 / R7 / R8 / R9 / R13: transmit sweep with one retry each
        for (int n = 0; n <= DEPTH; n++) begin
            do_flush();
            sw_write(n, n + 100);
            chk("R6 not armed yet", in_rdy, 0);
            do_tx_en();
            chk((n == 0) ? "R7 armed" : "R6 armed", in_rdy, 1);
            tok(K_IN, 1, 0);
            chk("R6 busy", tx_busy, 1);
            chk("R6 in_rdy low", in_rdy, 0);
            tx_pull_chk(n, n + 100, (n == 0) ? "R7" : "R6");
            do_end_err();
            chk("R8 rearmed", in_rdy, 1);
            chk("R8 not busy", tx_busy, 0);
            tok(K_IN, 1, 0);
            tx_pull_chk(n, n + 100, "R8 resend");
            do_end_ok();
            chk("R9 done", tx_done, 1);
            chk("R9 not busy", tx_busy, 0);
            chk("R9 not armed", in_rdy, 0);
            step();
            chk("R9 done one cycle", tx_done, 0);
            tok(K_IN, 1, 0);
            chk("R13 IN in idle", tx_busy, 0);
            do_tx_en();
            tok(K_IN, 1, 0);
            chk("R9 storage emptied", tx_empty, 1);
            do_end_ok();
        end

        // R12: overflow from software writes
        do_flush();
        sw_write(DEPTH + 2, 200);
        chk("R12 ovf set", ovf_flag, 1);
        do_tx_en();
        tok(K_IN, 1, 0);
        tx_pull_chk(DEPTH, 200, "R12");
        do_end_ok();
        chk("R12 ovf sticky", ovf_flag, 1);
        do_flush();
        chk("R12 ovf cleared", ovf_flag, 0);

        // R12: overflow from received bytes
        do_rx_en();
        tok(K_OUT, 1, 0);
        rx_body(DEPTH + 1, 210, 0);
        chk("R12 rx count capped", rx_count, DEPTH);
        chk("R12 rx ovf", ovf_flag, 1);
        sw_read_chk(DEPTH, 210, "R12 rx data");
        do_flush();

        // R10: SETUP while filling, then while armed
        sw_write(3, 300);
        tok(K_SETUP, 1, 0);
        chk("R10 fill taken", out_rdy, 0);
        chk("R10 in_rdy", in_rdy, 0);
        rx_body(2, 301, 0);
        chk("R10 ready", rx_ready, 1);
        chk("R10 count", rx_count, 2);
        sw_read_chk(2, 301, "R10 data");
        do_tx_en();
        tok(K_IN, 1, 0);
        chk("R10 tx data gone", tx_empty, 1);
        do_end_ok();
        sw_write(2, 310);
        do_tx_en();
        chk("R10 armed", in_rdy, 1);
        tok(K_SETUP, 1, 0);
        chk("R10 armed dropped", in_rdy, 0);
        rx_body(1, 311, 0);
        chk("R10 count armed", rx_count, 1);
        sw_read_chk(1, 311, "R10 data armed");

        // R13: unexpected tokens and enables
        sw_write(2, 320);
        do_tx_en();
        tok(K_OUT, 1, 0);
        chk("R13 OUT while armed tx", in_rdy, 1);
        do_rx_en();
        chk("R13 rx_en while armed tx", out_rdy, 0);
        tok(K_IN, 1, 0);
        tx_pull_chk(2, 320, "R13");
        do_end_ok();
        do_rx_en();
        tok(K_IN, 1, 0);
        chk("R13 IN while armed rx", tx_busy, 0);
        chk("R13 still armed rx", out_rdy, 1);

        // R11: flush from armed transmit and from held receive
        do_flush();
        sw_write(4, 400);
        do_tx_en();
        do_flush();
        chk("R11 disarmed", in_rdy, 0);
        tok(K_IN, 1, 0);
        chk("R11 IN ignored", tx_busy, 0);
        do_tx_en();
        tok(K_IN, 1, 0);
        chk("R11 storage empty", tx_empty, 1);
        do_end_ok();
        do_rx_en();
        tok(K_OUT, 1, 0);
        rx_body(3, 410, 0);
        do_flush();
        chk("R11 count cleared", rx_count, 0);
        do_rx_en();
        chk("R11 idle", out_rdy, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule